// File: doc/BRIEF.md
# Accumulator and Extension Register Datapath

This block holds an 8-bit accumulator, an 8-bit extension register, a carry flag and an overflow flag. Each clock where `op_valid` is high, it carries out one operation selected by `op_code`. The operand is either the byte on `operand_in` (a memory or immediate byte fetched by logic outside the block) or the extension register itself, as picked by `src_ext`.

The operations are:
- binary add with carry;
- packed-BCD add with carry;
- complement add, which takes the place of subtract;
- bitwise AND, OR and XOR;
- four right shifts and rotates of the accumulator;
- transfer and exchange between the accumulator and the extension register;
- direct setting and clearing of the carry flag;
- a one-bit serial step that shifts the extension register toward a serial output pin while sampling a serial input pin.

Instruction decoding, memory access and interrupts belong to the surrounding processor.

Top module: `acc_ext_datapath`

## Requirements
- R1: While `rst_n` is low, and after it is released with no operation issued, the accumulator, extension register, carry, overflow and `serial_out` all read 0.
- R2: Code 2 (binary add) loads the accumulator with (acc + opnd + carry) mod 256. Carry becomes the bit-8 carry-out. Overflow is set when acc and opnd have equal sign bits and the result sign bit differs from them.
- R3: Code 3 (decimal add) treats acc and opnd as two packed BCD digits and loads their decimal sum plus carry, mod 100. Carry is set when that sum exceeds 99. Overflow keeps its previous value.
- R4: Code 4 (complement add) loads (acc + (~opnd & 0xFF) + carry) mod 256. Carry and overflow are updated as in R2, with ~opnd taking the place of opnd.
- R5: Codes 5, 6 and 7 load acc AND opnd, acc OR opnd and acc XOR opnd. Carry and overflow are left unchanged.
- R6: Code 8 shifts the accumulator right one bit, inserting 0 at bit 7. Code 9 shifts it right, inserting carry at bit 7. Both discard bit 0 and leave carry unchanged.
- R7: Code 10 rotates the accumulator right, moving bit 0 to bit 7, with carry unchanged. Code 11 rotates the 9-bit value {carry, acc} right: old carry goes to bit 7 and old bit 0 goes to carry.
- R8: Code 1 copies opnd into the accumulator, so with `src_ext` = 1 it loads the extension register's value. Code 12 swaps the accumulator and the extension register.
- R9: Code 13 shifts the extension register right one bit. `serial_in` enters bit 7, and the old bit 0 appears on `serial_out` after that edge.
- R10: `serial_out` changes only on code 13 and otherwise holds its last value.
- R11: Code 14 sets carry to 1 and code 15 clears it to 0. Both leave the accumulator and overflow unchanged.
- R12: Code 0, or `op_valid` low, leaves every register and `serial_out` unchanged.
- R13: opnd is `operand_in` when `src_ext` = 0 and the extension register when `src_ext` = 1. Every result appears on the outputs one clock edge after the operation is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Perform `op_code` at this edge |
| op_code | input | 4 | Operation select (codes as in the requirements) |
| src_ext | input | 1 | Take the operand from the extension register |
| operand_in | input | 8 | Memory or immediate byte |
| serial_in | input | 1 | Serial input bit, entering extension bit 7 |
| serial_out | output | 1 | Last bit shifted out of extension bit 0 |
| acc_out | output | 8 | Accumulator |
| ext_out | output | 8 | Extension register |
| carry_out | output | 1 | Carry flag |
| ovf_out | output | 1 | Overflow flag |

## Verification
The embedded properties check on every cycle the rules about which state an operation may disturb:
- overflow is held across a decimal add;
- both flags are held across the logic operations;
- the serial step moves bit 0 to `serial_out` and `serial_in` into bit 7;
- `serial_out` is held between serial steps;
- carry is forced by the set and clear operations.

The arithmetic values need the bench's scenarios. These are the BCD digit corrections, the overflow boundaries at 0x7F/0x80, the complement-add results and the 9-bit rotate. The bench compares them against an integer model of the requirements after every operation, including a long run of mixed random operations.

// File: rtl/acc_ext_pkg.sv
package acc_ext_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 4'd0,
        OP_LOAD   = 4'd1,
        OP_ADD    = 4'd2,
        OP_DADD   = 4'd3,
        OP_CADD   = 4'd4,
        OP_AND    = 4'd5,
        OP_OR     = 4'd6,
        OP_XOR    = 4'd7,
        OP_SHR    = 4'd8,
        OP_SHRL   = 4'd9,
        OP_ROR    = 4'd10,
        OP_RORC   = 4'd11,
        OP_XCHG   = 4'd12,
        OP_SERIAL = 4'd13,
        OP_SETC   = 4'd14,
        OP_CLRC   = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        SH_ZERO  = 2'd0,
        SH_LINK  = 2'd1,
        SH_ROT   = 2'd2,
        SH_ROTC  = 2'd3
    } shift_e;

endpackage

// File: rtl/acc_ext_adder.sv
module acc_ext_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         dec_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int DIGITS = W / 4;

    logic [W-1:0] bin_sum;
    logic         bin_cout;
    logic [W-1:0] dec_sum;
    logic         dec_cout;
    logic [4:0]   digit;
    logic         dcarry;

    always_comb begin
        {bin_cout, bin_sum} = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    end

    always_comb begin
        dec_sum = '0;
        dcarry  = cin_i;
        digit   = '0;
        for (int i = 0; i < DIGITS; i++) begin
            digit = {1'b0, a_i[4*i +: 4]} + {1'b0, b_i[4*i +: 4]} + {4'd0, dcarry};
            if (digit > 5'd9) begin
                digit  = digit + 5'd6;
                dcarry = 1'b1;
            end else begin
                dcarry = 1'b0;
            end
            dec_sum[4*i +: 4] = digit[3:0];
        end
        dec_cout = dcarry;
    end

    always_comb begin
        sum_o  = dec_i ? dec_sum : bin_sum;
        cout_o = dec_i ? dec_cout : bin_cout;
        ovf_o  = (a_i[W-1] == b_i[W-1]) && (bin_sum[W-1] != a_i[W-1]);
    end

endmodule

// File: rtl/acc_ext_shifter.sv
module acc_ext_shifter
    import acc_ext_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         cin_i,
    input  shift_e       mode_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    always_comb begin
        res_o  = {1'b0, val_i[W-1:1]};
        cout_o = cin_i;
        unique case (mode_i)
            SH_ZERO: res_o = {1'b0, val_i[W-1:1]};
            SH_LINK: res_o = {cin_i, val_i[W-1:1]};
            SH_ROT:  res_o = {val_i[0], val_i[W-1:1]};
            SH_ROTC: begin
                res_o  = {cin_i, val_i[W-1:1]};
                cout_o = val_i[0];
            end
            default: res_o = {1'b0, val_i[W-1:1]};
        endcase
    end
endmodule

// File: rtl/acc_ext_datapath.sv
module acc_ext_datapath
    import acc_ext_pkg::*;
#(
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic            src_ext,
    input  logic [W-1:0]    operand_in,
    input  logic            serial_in,
    output logic            serial_out,
    output logic [W-1:0]    acc_out,
    output logic [W-1:0]    ext_out,
    output logic            carry_out,
    output logic            ovf_out
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic [W-1:0] ext;
        logic         cy;
        logic         ov;
        logic         so;
    } state_t;

    state_t st_d, st_q;
    op_e    op;

    logic [W-1:0] opnd;
    logic [W-1:0] add_b;
    logic         add_dec;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    shift_e       sh_mode;
    logic [W-1:0] sh_res;
    logic         sh_cout;

    always_comb begin
        op      = op_e'(op_code);
        opnd    = src_ext ? st_q.ext : operand_in;
        add_b   = (op == OP_CADD) ? ~opnd : opnd;
        add_dec = (op == OP_DADD);
        sh_mode = shift_e'(op_code[1:0]);
    end

    acc_ext_adder #(.W(W)) u_add (
        .a_i    (st_q.acc),
        .b_i    (add_b),
        .cin_i  (st_q.cy),
        .dec_i  (add_dec),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    acc_ext_shifter #(.W(W)) u_shift (
        .val_i  (st_q.acc),
        .cin_i  (st_q.cy),
        .mode_i (sh_mode),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            unique case (op)
                OP_NOP:  ;
                OP_LOAD: st_d.acc = opnd;
                OP_ADD, OP_CADD: begin
                    st_d.acc = add_sum;
                    st_d.cy  = add_cout;
                    st_d.ov  = add_ovf;
                end
                OP_DADD: begin
                    st_d.acc = add_sum;
                    st_d.cy  = add_cout;
                end
                OP_AND: st_d.acc = st_q.acc & opnd;
                OP_OR:  st_d.acc = st_q.acc | opnd;
                OP_XOR: st_d.acc = st_q.acc ^ opnd;
                OP_SHR, OP_SHRL, OP_ROR, OP_RORC: begin
                    st_d.acc = sh_res;
                    st_d.cy  = sh_cout;
                end
                OP_XCHG: begin
                    st_d.acc = st_q.ext;
                    st_d.ext = st_q.acc;
                end
                OP_SERIAL: begin
                    st_d.ext = {serial_in, st_q.ext[W-1:1]};
                    st_d.so  = st_q.ext[0];
                end
                OP_SETC: st_d.cy = 1'b1;
                OP_CLRC: st_d.cy = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out    = st_q.acc;
    assign ext_out    = st_q.ext;
    assign carry_out  = st_q.cy;
    assign ovf_out    = st_q.ov;
    assign serial_out = st_q.so;

    // R3
    dec_keeps_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd3) |=> $stable(ovf_out));

    // R5
    logic_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd5 || op_code == 4'd6 || op_code == 4'd7))
        |=> ($stable(carry_out) && $stable(ovf_out)));

    // R9
    serial_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd13)
        |=> (serial_out == $past(ext_out[0]) && ext_out[W-1] == $past(serial_in)));

    // R10
    serial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_code == 4'd13) |=> $stable(serial_out));

    // R11
    set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd14) |=> (carry_out && $stable(acc_out)));

    // R11
    clr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd15) |=> (!carry_out && $stable(acc_out)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=> ($stable(acc_out) && $stable(ext_out) && $stable(carry_out)));

endmodule

// File: tb/sim_acc_ext_datapath.sv
module sim_acc_ext_datapath;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [3:0] op_code;
    logic       src_ext;
    logic [7:0] operand_in;
    logic       serial_in;
    logic       serial_out;
    logic [7:0] acc_out;
    logic [7:0] ext_out;
    logic       carry_out;
    logic       ovf_out;

    int errors = 0;
    int checks = 0;

    int m_ac, m_e, m_c, m_ov, m_so;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_ext_datapath u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .src_ext    (src_ext),
        .operand_in (operand_in),
        .serial_in  (serial_in),
        .serial_out (serial_out),
        .acc_out    (acc_out),
        .ext_out    (ext_out),
        .carry_out  (carry_out),
        .ovf_out    (ovf_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "acc", int'(acc_out), m_ac);
        chk(req, "ext", int'(ext_out), m_e);
        chk(req, "carry", int'(carry_out), m_c);
        chk(req, "ovf", int'(ovf_out), m_ov);
        chk(req, "serial_out", int'(serial_out), m_so);
    endtask

    function automatic int bcd2i(input int x);
        return ((x >> 4) & 15) * 10 + (x & 15);
    endfunction

    function automatic int i2bcd(input int x);
        return ((x / 10) << 4) | (x % 10);
    endfunction

    function automatic int sgn(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic string req_of(input int op, input bit v);
        if (!v || op == 0) return "R12";
        case (op)
            1, 12:    return "R8";
            2:        return "R2";
            3:        return "R3";
            4:        return "R4";
            5, 6, 7:  return "R5";
            8, 9:     return "R6";
            10, 11:   return "R7";
            13:       return "R9";
            default:  return "R11";
        endcase
    endfunction

    task automatic model(input bit v, input int op, input bit se, input int d, input int sin);
        int b, s, sv, old_ac;
        if (!v) return;
        b = se ? m_e : d;
        old_ac = m_ac;
        case (op)
            1: m_ac = b;
            2, 4: begin
                if (op == 4) b = (~b) & 255;
                s  = m_ac + b + m_c;
                sv = sgn(m_ac) + sgn(b) + m_c;
                m_ac = s % 256;
                m_c  = (s > 255) ? 1 : 0;
                m_ov = (sv > 127 || sv < -128) ? 1 : 0;
            end
            3: begin
                s = bcd2i(m_ac) + bcd2i(b) + m_c;
                m_c  = (s > 99) ? 1 : 0;
                m_ac = i2bcd(s % 100);
            end
            5: m_ac = m_ac & b;
            6: m_ac = m_ac | b;
            7: m_ac = m_ac ^ b;
            8: m_ac = old_ac / 2;
            9: m_ac = old_ac / 2 + m_c * 128;
            10: m_ac = old_ac / 2 + (old_ac % 2) * 128;
            11: begin
                m_ac = old_ac / 2 + m_c * 128;
                m_c  = old_ac % 2;
            end
            12: begin
                m_ac = m_e;
                m_e  = old_ac;
            end
            13: begin
                m_so = m_e % 2;
                m_e  = m_e / 2 + sin * 128;
            end
            14: m_c = 1;
            15: m_c = 0;
            default: ;
        endcase
    endtask

    task automatic step(input bit v, input int op, input bit se, input int d, input int sin);
        op_valid   = v;
        op_code    = 4'(op);
        src_ext    = se;
        operand_in = 8'(d);
        serial_in  = 1'(sin);
        model(v, op, se, d, sin);
        @(posedge clk);
        @(negedge clk);
        compare_all(req_of(op, v));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        op_valid = 1'b0;
        op_code = '0;
        src_ext = 1'b0;
        operand_in = '0;
        serial_in = 1'b0;
        m_ac = 0; m_e = 0; m_c = 0; m_ov = 0; m_so = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        compare_all("R1");

        // R2 overflow boundary 0x7F + 1, then carry-out at 0xFF + 1
        step(1, 1, 0, 8'h7F, 0);
        step(1, 2, 0, 8'h01, 0);
        step(1, 1, 0, 8'hFF, 0);
        step(1, 2, 0, 8'h01, 0);
        step(1, 2, 0, 8'h80, 0);
        // R3 decimal add with digit corrections, overflow held
        step(1, 15, 0, 0, 0);
        step(1, 1, 0, 8'h45, 0);
        step(1, 3, 0, 8'h38, 0);
        step(1, 3, 0, 8'h17, 0);
        step(1, 1, 0, 8'h99, 0);
        step(1, 14, 0, 0, 0);
        step(1, 3, 0, 8'h00, 0);
        // R4 complement add as subtract, borrow and overflow cases
        step(1, 14, 0, 0, 0);
        step(1, 1, 0, 8'h50, 0);
        step(1, 4, 0, 8'h20, 0);
        step(1, 4, 0, 8'h40, 0);
        step(1, 1, 0, 8'h80, 0);
        step(1, 4, 0, 8'h01, 0);
        // R8 exchange and load from extension, R13 source select
        step(1, 1, 0, 8'hA5, 0);
        step(1, 12, 0, 0, 0);
        step(1, 1, 0, 8'h3C, 0);
        step(1, 5, 1, 8'hFF, 0);
        step(1, 6, 1, 8'h00, 0);
        step(1, 7, 0, 8'hFF, 0);
        step(1, 1, 1, 8'h00, 0);
        // R6 / R7 shifts and rotates with carry set and clear
        step(1, 14, 0, 0, 0);
        step(1, 9, 0, 0, 0);
        step(1, 8, 0, 0, 0);
        step(1, 11, 0, 0, 0);
        step(1, 11, 0, 0, 0);
        step(1, 10, 0, 0, 0);
        step(1, 15, 0, 0, 0);
        step(1, 9, 0, 0, 0);
        // R9 / R10 serial steps, with holds in between
        for (int i = 0; i < 10; i++) begin
            step(1, 13, 0, 0, i % 3 == 0 ? 1 : 0);
            step(1, 1, 0, i * 17, 1);
        end
        // R12 idle and NOP with junk inputs
        step(0, 2, 0, 8'hFF, 1);
        step(1, 0, 1, 8'h12, 1);
        step(0, 13, 0, 8'h00, 1);

        // mixed random run (decimal add excluded: needs BCD operands)
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 15);
            if (op == 3) op = 2;
            step($urandom_range(0, 7) != 0, op, $urandom_range(0, 1) == 1,
                 $urandom_range(0, 255), $urandom_range(0, 1));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule